// File: doc/BRIEF.md
# 8x8 Bit-Matrix Multiply Unit

A purely combinational datapath unit that reads each 64-bit operand as an 8x8 matrix of bits. Byte r of an operand is row r of the matrix, and bit c of that byte is column c. Three operations are selected by a 2-bit code.

The first operation transposes operand A. The second multiplies A by B over GF(2), so AND forms the products and XOR sums them. The third forms the Boolean product of A and B, so AND forms the products and OR sums them. Both multiplies first transpose B so that its columns become bytes. Each result bit then comes from one byte of A and one byte of the transposed B.

The unit sits inside an execution pipeline stage. Decoding, operand fetch and flag generation belong to the surrounding stage.

Top module: `bmm_unit`

## Requirements
- R1: With op_i = 2'b00, bit 8*k+j of res_o equals bit 8*j+k of a_i for all j, k in 0..7 (bit k of byte j moves to bit j of byte k).
- R2: Applying the op 2'b00 transpose to its own result returns the original a_i.
- R3: With op_i = 2'b00, the number of set bits in res_o equals the number of set bits in a_i.
- R4: With op_i = 2'b01, bit 8*r+c of res_o is the XOR over k of (a_i[8*r+k] AND b_i[8*k+c]).
- R5: With op_i = 2'b10, bit 8*r+c of res_o is the OR over k of (a_i[8*r+k] AND b_i[8*k+c]).
- R6: With op_i = 2'b11, res_o is all zeros whatever a_i and b_i are.
- R7: With b_i equal to the identity matrix 64'h8040201008040201 (byte n has only bit n set), both op 2'b01 and op 2'b10 return a_i.
- R8: For the same operands, every bit set in the op 2'b01 result is also set in the op 2'b10 result.
- R9: When a_i is zero, both op 2'b01 and op 2'b10 return zero for any b_i.
- R10: With op_i = 2'b00, b_i has no effect on res_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 64 | Operand A; byte r is row r |
| b_i | input | 64 | Operand B; byte r is row r |
| op_i | input | 2 | 00 transpose A, 01 GF(2) product, 10 Boolean product, 11 zero |
| res_o | output | 64 | Result matrix |

## Verification
Immediate assertions are evaluated on every input change. They check the following relations between the separately built pieces of logic: the transpose keeps the popcount, the reserved code gives zero, the GF(2) product is a subset of the Boolean product, a zero A gives zero products, and an identity B returns A. The exact bit positions of the transpose and of both products are shown only by the bench, which compares the outputs against loop-based reference models. The same holds for the transpose returning the original when applied twice and for B being ignored during a transpose. The bench drives a full single-bit sweep of A for every code and several hundred random operand pairs.

// File: rtl/bmm_pkg.sv
package bmm_pkg;
  localparam int unsigned DIM = 8;
  localparam int unsigned MW  = DIM * DIM;

  typedef enum logic [1:0] {
    OP_FLIP = 2'b00,
    OP_XMUL = 2'b01,
    OP_OMUL = 2'b10,
    OP_NONE = 2'b11
  } bmm_op_e;

  function automatic logic [MW-1:0] ident_mat();
    logic [MW-1:0] m;
    m = '0;
    for (int n = 0; n < DIM; n++) m[n*DIM+n] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/bmm_flip.sv
module bmm_flip #(
  parameter int unsigned DIM = 8,
  localparam int unsigned MW = DIM * DIM
) (
  input  logic [MW-1:0] mat_i,
  output logic [MW-1:0] mat_o
);
  for (genvar j = 0; j < DIM; j++) begin : g_row
    for (genvar k = 0; k < DIM; k++) begin : g_col
      assign mat_o[k*DIM+j] = mat_i[j*DIM+k];
    end
  end
endmodule

// File: rtl/bmm_mul.sv
module bmm_mul #(
  parameter int unsigned DIM     = 8,
  parameter bit          OR_MODE = 1'b0,
  localparam int unsigned MW     = DIM * DIM
) (
  input  logic [MW-1:0] row_i,   // A, rows as bytes
  input  logic [MW-1:0] colt_i,  // transposed B, columns as bytes
  output logic [MW-1:0] res_o
);
  for (genvar r = 0; r < DIM; r++) begin : g_r
    for (genvar c = 0; c < DIM; c++) begin : g_c
      logic [DIM-1:0] term;
      assign term = row_i[r*DIM +: DIM] & colt_i[c*DIM +: DIM];
      if (OR_MODE) begin : g_or
        assign res_o[r*DIM+c] = |term;
      end else begin : g_xor
        assign res_o[r*DIM+c] = ^term;
      end
    end
  end
endmodule

// File: rtl/bmm_unit.sv
module bmm_unit
  import bmm_pkg::*;
(
  input  logic [63:0] a_i,
  input  logic [63:0] b_i,
  input  logic [1:0]  op_i,
  output logic [63:0] res_o
);
  localparam logic [MW-1:0] IDENT = ident_mat();

  logic [MW-1:0] a_flip, b_flip, xmul, omul;

  bmm_flip #(.DIM(DIM)) u_flip_a (.mat_i(a_i), .mat_o(a_flip));
  bmm_flip #(.DIM(DIM)) u_flip_b (.mat_i(b_i), .mat_o(b_flip));

  bmm_mul #(.DIM(DIM), .OR_MODE(1'b0)) u_xmul (.row_i(a_i), .colt_i(b_flip), .res_o(xmul));
  bmm_mul #(.DIM(DIM), .OR_MODE(1'b1)) u_omul (.row_i(a_i), .colt_i(b_flip), .res_o(omul));

  always_comb begin
    case (bmm_op_e'(op_i))
      OP_FLIP: res_o = a_flip;
      OP_XMUL: res_o = xmul;
      OP_OMUL: res_o = omul;
      default: res_o = '0;
    endcase
  end

  always_comb begin
    assert_flip_popcnt_R3: assert (op_i != OP_FLIP || $countones(res_o) == $countones(a_i));
    assert_none_zero_R6:   assert (op_i != OP_NONE || res_o == '0);
    assert_ident_keep_R7:  assert (b_i != IDENT || (xmul == a_i && omul == a_i));
    assert_xor_in_or_R8:   assert ((xmul & ~omul) == '0);
    assert_zero_a_R9:      assert (a_i != '0 || (xmul == '0 && omul == '0));
  end
endmodule

// File: tb/tb_bmm_unit.sv
`timescale 1ns/1ps
module tb_bmm_unit;
  localparam logic [63:0] IDENT = 64'h8040201008040201;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [63:0] a, b, res;
  logic [1:0] op;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bmm_unit dut (.a_i(a), .b_i(b), .op_i(op), .res_o(res));

  function automatic logic [63:0] ref_flip(logic [63:0] x);
    logic [63:0] y = '0;
    for (int j = 0; j < 8; j++)
      for (int k = 0; k < 8; k++) y[k*8+j] = x[j*8+k];
    return y;
  endfunction

  function automatic logic [63:0] ref_mul(logic [63:0] x, logic [63:0] y, bit use_or);
    logic [63:0] z = '0;
    for (int r = 0; r < 8; r++)
      for (int c = 0; c < 8; c++) begin
        logic acc = 1'b0;
        for (int k = 0; k < 8; k++)
          acc = use_or ? (acc | (x[r*8+k] & y[k*8+c])) : (acc ^ (x[r*8+k] & y[k*8+c]));
        z[r*8+c] = acc;
      end
    return z;
  endfunction

  function automatic logic [63:0] ref_op(logic [63:0] x, logic [63:0] y, logic [1:0] o);
    case (o)
      2'b00:   return ref_flip(x);
      2'b01:   return ref_mul(x, y, 1'b0);
      2'b10:   return ref_mul(x, y, 1'b1);
      default: return 64'h0;
    endcase
  endfunction

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  task automatic drive(logic [63:0] x, logic [63:0] y, logic [1:0] o);
    @(negedge clk);
    a = x; b = y; op = o;
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic string op_req(logic [1:0] o);
    case (o)
      2'b00:   return "R1";
      2'b01:   return "R4";
      2'b10:   return "R5";
      default: return "R6";
    endcase
  endfunction

  initial begin
    #(100000 * 8);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] x, y, r1, r2;
    a = '0; b = '0; op = 2'b00;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    drive('0, '0, 2'b00);
    chk("R1 zero", res, 64'h0);

    // single-bit sweep of A, all codes
    for (int i = 0; i < 64; i++)
      for (int o = 0; o < 4; o++) begin
        y = rnd64();
        drive(64'h1 << i, y, 2'(o));
        chk(op_req(2'(o)), res, ref_op(64'h1 << i, y, 2'(o)));
      end

    // random operands, all codes
    for (int n = 0; n < 400; n++) begin
      x = rnd64(); y = rnd64();
      for (int o = 0; o < 4; o++) begin
        drive(x, y, 2'(o));
        chk(op_req(2'(o)), res, ref_op(x, y, 2'(o)));
      end
    end

    // dense and sparse corner patterns
    drive('1, '1, 2'b01); chk("R4 ones", res, 64'h0);
    drive('1, '1, 2'b10); chk("R5 ones", res, '1);
    drive('1, '1, 2'b11); chk("R6 ones", res, 64'h0);

    for (int n = 0; n < 100; n++) begin
      x = rnd64();
      drive(x, rnd64(), 2'b00); r1 = res;
      drive(r1, rnd64(), 2'b00);
      chk("R2", res, x);
      chk("R3", 64'($countones(r1)), 64'($countones(x)));
    end

    for (int n = 0; n < 50; n++) begin
      x = rnd64();
      drive(x, IDENT, 2'b01); chk("R7 xor", res, x);
      drive(x, IDENT, 2'b10); chk("R7 or", res, x);
    end

    for (int n = 0; n < 100; n++) begin
      x = rnd64(); y = rnd64();
      drive(x, y, 2'b01); r1 = res;
      drive(x, y, 2'b10); r2 = res;
      chk("R8", r1 & ~r2, 64'h0);
    end

    for (int n = 0; n < 50; n++) begin
      y = rnd64();
      drive('0, y, 2'b01); chk("R9 xor", res, 64'h0);
      drive('0, y, 2'b10); chk("R9 or", res, 64'h0);
    end

    for (int n = 0; n < 50; n++) begin
      x = rnd64();
      drive(x, '0, 2'b00); r1 = res;
      drive(x, '1, 2'b00); r2 = res;
      chk("R10", r2, r1);
      drive(x, rnd64(), 2'b00);
      chk("R10", res, ref_flip(x));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule